// File: doc/BRIEF.md
# Frame Checksum Engine (CRC-8, 24-bit payload)

This block produces and checks the 8-bit checksum that protects a 32-bit serial frame. The checksum covers the upper three bytes of the frame, taken most significant bit first. The frame's own low byte is the checksum slot, and it never enters the calculation. A transmitter uses the result to fill that slot. A receiver compares the result against the byte that arrived in the slot.

There are two ways to feed the engine. In the first, the whole 24-bit payload is presented in one cycle and the checksum appears on the next cycle. In the second, the payload arrives one bit per qualified cycle after a start strobe, and a done flag rises once the last payload bit has been absorbed. The generator is x^8+x^4+x^3+x^2+1. The shift register is preset to all ones, so a line stuck at 0 or at 1 still gives a checksum that differs from the data. The register is complemented on its way to the output.

Top module: `crc8_frame_check`

## Requirements
- R1: After reset, crcOut reads 0x00 (the complemented all-ones preset), done is 0 and match is 0.
- R2: The checksum uses polynomial 0x1D, preset 0xFF and final complement, over payload bits 23 down to 0 (frame bits 31..8). Payload 0x040000 gives 0xF7, 0x05FFE0 gives 0x8B and 0x1100DC gives 0x02.
- R3: A cycle with parValid high loads the checksum of parWord. In the next cycle done is 1 and crcOut holds that checksum.
- R4: In serial mode, serBit is taken most significant bit first on each cycle with serBitValid high. done stays 0 after 23 bits and is 1 in the cycle after the 24th bit. crcOut then equals the parallel checksum of the same payload.
- R5: Cycles with serBitValid low leave the checksum and the bit count unchanged, whatever the value of serBit.
- R6: Once done is 1, further qualified bits are ignored and crcOut stays constant until the next serStart or parValid.
- R7: serStart alone (serBitValid low) presets the register and clears the count. In the next cycle crcOut is 0x00 and done is 0.
- R8: serStart together with serBitValid presets the register and takes that cycle's bit as the first bit of the new payload. Any partial payload from before is discarded.
- R9: parValid has priority over serStart and serBitValid in the same cycle. The result is the parallel checksum, and done is 1 on the next cycle.
- R10: match is 1 exactly when done is 1 and crcOut equals refByte. It is 0 while done is 0, even when the bytes are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| parValid | input | 1 | Load the checksum of parWord in one cycle |
| parWord | input | 24 | Payload for the single-cycle path (frame bits 31..8) |
| serStart | input | 1 | Preset the register and restart the serial bit count |
| serBitValid | input | 1 | serBit is a payload bit this cycle |
| serBit | input | 1 | Serial payload bit, most significant first |
| refByte | input | 8 | Received checksum byte to compare against |
| crcOut | output | 8 | Complemented checksum register |
| done | output | 1 | A full payload has been absorbed |
| match | output | 1 | done and crcOut equals refByte |

## Verification
Three inputs can coincide in one cycle. A start strobe can arrive together with a qualified bit, which must both restart the frame and consume that bit. A parallel load can arrive together with serial activity, and the parallel word must win. Both cases are provoked after leaving a partial serial payload in the register. The result is judged against an independently computed checksum of the new payload only, and done must rise in the expected cycle. The bench also checks that bits arriving after done, and bits with the valid flag low, leave crcOut unchanged.

// File: rtl/crc8_frame_pkg.sv
package crc8_frame_pkg;
  localparam int unsigned DEF_DATA_BITS = 24;
  localparam int unsigned DEF_CRC_W     = 8;

  // Strobes from the sequencing logic to the checksum register
  typedef struct packed {
    logic presetSeed; // start the register from the preset value
    logic shiftEn;    // absorb serBit this cycle
    logic parLoad;    // load the single-cycle result
  } crcCtrl_t;
endpackage

// File: rtl/crc8_ctrl.sv
module crc8_ctrl
  import crc8_frame_pkg::*;
#(
  parameter int unsigned DATA_BITS = DEF_DATA_BITS
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     parValid,
  input  logic     serStart,
  input  logic     serBitValid,
  output crcCtrl_t ctrl,
  output logic     done
);
  localparam int unsigned CNT_W = $clog2(DATA_BITS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_BITS);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [CNT_W-1:0] bitCount;
  logic             frameOpen;

  assign frameOpen = serStart || (bitCount < FULL_CNT);

  always_comb begin
    ctrl.parLoad    = parValid;
    ctrl.presetSeed = serStart && !parValid;
    ctrl.shiftEn    = serBitValid && frameOpen && !parValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (ctrl.parLoad) begin
      bitCount <= FULL_CNT;
    end else if (ctrl.presetSeed) begin
      bitCount <= ctrl.shiftEn ? ONE_CNT : '0;
    end else if (ctrl.shiftEn) begin
      bitCount <= bitCount + ONE_CNT;
    end
  end

  assign done = (bitCount == FULL_CNT);
endmodule

// File: rtl/crc8_datapath.sv
module crc8_datapath
  import crc8_frame_pkg::*;
#(
  parameter int unsigned      DATA_BITS = DEF_DATA_BITS,
  parameter int unsigned      CRC_W     = DEF_CRC_W,
  parameter logic [CRC_W-1:0] POLY      = 8'h1D,
  parameter logic [CRC_W-1:0] SEED      = 8'hFF,
  parameter logic [CRC_W-1:0] XOR_OUT   = 8'hFF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  crcCtrl_t             ctrl,
  input  logic [DATA_BITS-1:0] parWord,
  input  logic                 serBit,
  input  logic [CRC_W-1:0]     refByte,
  input  logic                 done,
  output logic [CRC_W-1:0]     crcOut,
  output logic                 match
);
  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] parResult;
  logic [CRC_W-1:0] serBase;
  logic [CRC_W-1:0] serResult;

  function automatic logic [CRC_W-1:0] stepBit(input logic [CRC_W-1:0] st,
                                                input logic inBit);
    logic fb;
    fb = st[CRC_W-1] ^ inBit;
    return {st[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  // Unrolled chain of single-bit steps, most significant payload bit first
  always_comb begin
    parResult = SEED;
    for (int i = DATA_BITS - 1; i >= 0; i--) begin
      parResult = stepBit(parResult, parWord[i]);
    end
  end

  assign serBase   = ctrl.presetSeed ? SEED : crcReg;
  assign serResult = stepBit(serBase, serBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg <= SEED;
    end else if (ctrl.parLoad) begin
      crcReg <= parResult;
    end else if (ctrl.shiftEn) begin
      crcReg <= serResult;
    end else if (ctrl.presetSeed) begin
      crcReg <= SEED;
    end
  end

  assign crcOut = crcReg ^ XOR_OUT;
  assign match  = done && (crcOut == refByte);
endmodule

// File: rtl/crc8_frame_check.sv
module crc8_frame_check
  import crc8_frame_pkg::*;
#(
  parameter int unsigned      DATA_BITS = DEF_DATA_BITS,
  parameter int unsigned      CRC_W     = DEF_CRC_W,
  parameter logic [CRC_W-1:0] POLY      = 8'h1D,
  parameter logic [CRC_W-1:0] SEED      = 8'hFF,
  parameter logic [CRC_W-1:0] XOR_OUT   = 8'hFF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 parValid,
  input  logic [DATA_BITS-1:0] parWord,
  input  logic                 serStart,
  input  logic                 serBitValid,
  input  logic                 serBit,
  input  logic [CRC_W-1:0]     refByte,
  output logic [CRC_W-1:0]     crcOut,
  output logic                 done,
  output logic                 match
);
  crcCtrl_t ctrlBus;

  crc8_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .parValid   (parValid),
    .serStart   (serStart),
    .serBitValid(serBitValid),
    .ctrl       (ctrlBus),
    .done       (done)
  );

  crc8_datapath #(
    .DATA_BITS(DATA_BITS),
    .CRC_W    (CRC_W),
    .POLY     (POLY),
    .SEED     (SEED),
    .XOR_OUT  (XOR_OUT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrlBus),
    .parWord(parWord),
    .serBit (serBit),
    .refByte(refByte),
    .done   (done),
    .crcOut (crcOut),
    .match  (match)
  );
endmodule

// File: rtl/crc8_frame_check_sva.sv
module crc8_frame_check_sva #(
  parameter int unsigned DATA_BITS = 24,
  parameter int unsigned CRC_W     = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 parValid,
  input logic [DATA_BITS-1:0] parWord,
  input logic                 serStart,
  input logic                 serBitValid,
  input logic                 serBit,
  input logic [CRC_W-1:0]     refByte,
  input logic [CRC_W-1:0]     crcOut,
  input logic                 done,
  input logic                 match
);
  assert_par_sets_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    parValid |=> done);

  assert_start_presets_R7: assert property (@(posedge clk) disable iff (!rstN)
    (serStart && !serBitValid && !parValid) |=> (crcOut == '0 && !done));

  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !serStart && !parValid) |=> ($stable(crcOut) && done));

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!serBitValid && !serStart && !parValid) |=> $stable(crcOut));

  assert_match_needs_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    match |-> (done && crcOut == refByte));

  assert_done_rise_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(serBitValid || parValid));
endmodule

bind crc8_frame_check crc8_frame_check_sva #(
  .DATA_BITS(DATA_BITS),
  .CRC_W    (CRC_W)
) u_sva (.*);

// File: tb/sim_crc8_frame_check.sv
module sim_crc8_frame_check;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        parValid = 1'b0;
  logic [23:0] parWord = '0;
  logic        serStart = 1'b0;
  logic        serBitValid = 1'b0;
  logic        serBit = 1'b0;
  logic [7:0]  refByte = '0;
  logic [7:0]  crcOut;
  logic        done;
  logic        match;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  crc8_frame_check u0 (
    .clk(clk), .rstN(rstN), .parValid(parValid), .parWord(parWord),
    .serStart(serStart), .serBitValid(serBitValid), .serBit(serBit),
    .refByte(refByte), .crcOut(crcOut), .done(done), .match(match)
  );

  // Reference checksum written from the requirement text (R2)
  function automatic logic [7:0] refCrc(input logic [23:0] w);
    logic [7:0] r;
    r = 8'hFF;
    for (int i = 23; i >= 0; i--) begin
      if (r[7] ^ w[i]) r = (r << 1) ^ 8'h1D;
      else             r = r << 1;
    end
    return ~r;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    serBitValid = 1'b1;
    serBit = b;
    tick();
    serBitValid = 1'b0;
    serBit = 1'b0;
  endtask

  task automatic testReset();
    check("R1 crcOut", crcOut, 8'h00);
    check("R1 done", done, 1'b0);
    check("R1 match", match, 1'b0);
  endtask

  task automatic testParallel();
    logic [23:0] words [3];
    logic [7:0]  sums [3];
    words[0] = 24'h040000; sums[0] = 8'hF7;
    words[1] = 24'h05FFE0; sums[1] = 8'h8B;
    words[2] = 24'h1100DC; sums[2] = 8'h02;
    for (int k = 0; k < 3; k++) begin
      parValid = 1'b1;
      parWord = words[k];
      refByte = sums[k];
      tick();
      parValid = 1'b0;
      check("R2 known vector", crcOut, sums[k]);
      check("R2 bench model", refCrc(words[k]), sums[k]);
      check("R3 done after load", done, 1'b1);
      check("R10 match equal", match, 1'b1);
      refByte = sums[k] ^ 8'h01;
      #0.5;
      check("R10 match unequal", match, 1'b0);
    end
  endtask

  task automatic testSerial(input logic [23:0] w);
    serStart = 1'b1;
    tick();
    serStart = 1'b0;
    for (int i = 23; i >= 1; i--) sendBit(w[i]);
    check("R4 done low after 23 bits", done, 1'b0);
    sendBit(w[0]);
    check("R4 done after 24 bits", done, 1'b1);
    check("R4 serial equals parallel", crcOut, refCrc(w));
  endtask

  task automatic testGaps(input logic [23:0] w);
    logic [7:0] held;
    serStart = 1'b1;
    tick();
    serStart = 1'b0;
    for (int i = 23; i >= 0; i--) begin
      held = crcOut;
      serBit = ~w[i];
      tick();
      tick();
      check("R5 idle bit ignored", crcOut, held);
      sendBit(w[i]);
    end
    check("R5 gapped frame", crcOut, refCrc(w));
    check("R5 done", done, 1'b1);
  endtask

  task automatic testAfterDone();
    logic [7:0] held;
    held = crcOut;
    for (int i = 0; i < 6; i++) sendBit(i[0]);
    check("R6 extra bits ignored", crcOut, held);
    check("R6 done held", done, 1'b1);
  endtask

  task automatic testStart();
    refByte = 8'h00;
    serStart = 1'b1;
    tick();
    serStart = 1'b0;
    check("R7 preset output", crcOut, 8'h00);
    check("R7 done cleared", done, 1'b0);
    check("R10 no match before done", match, 1'b0);
  endtask

  task automatic testStartWithBit(input logic [23:0] w);
    serStart = 1'b1;
    tick();
    serStart = 1'b0;
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    serStart = 1'b1;
    sendBit(w[23]);
    serStart = 1'b0;
    check("R8 count restarted", done, 1'b0);
    for (int i = 22; i >= 0; i--) sendBit(w[i]);
    check("R8 start plus bit", crcOut, refCrc(w));
    check("R8 done", done, 1'b1);
  endtask

  task automatic testParOverride(input logic [23:0] w);
    serStart = 1'b1;
    tick();
    serStart = 1'b0;
    for (int i = 0; i < 7; i++) sendBit(i[1]);
    parValid = 1'b1;
    parWord = w;
    serStart = 1'b1;
    serBitValid = 1'b1;
    serBit = 1'b1;
    refByte = refCrc(w);
    tick();
    parValid = 1'b0;
    serStart = 1'b0;
    serBitValid = 1'b0;
    check("R9 parallel wins", crcOut, refCrc(w));
    check("R9 done", done, 1'b1);
    check("R10 match after override", match, 1'b1);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0x1 expected=0x0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #12;
    rstN = 1'b1;
    tick();
    testReset();
    testParallel();
    testSerial(24'h040000);
    testSerial(24'hA5C3F0);
    testGaps(24'h5A0F81);
    testAfterDone();
    testStart();
    testStartWithBit(24'h1100DC);
    testParOverride(24'h05FFE0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule